// File: doc/BRIEF.md
# Lock-Step Binary and Gray Up-Counter

This block is an up-counter that keeps two registers side by side: a plain binary count and a Gray-coded copy of the same count. Both registers load on the same clock edge. The incremented binary value is formed as an explicit next-state signal. That one signal feeds the binary register and, through a per-bit XOR encoder, the Gray register. The two outputs therefore never differ by a cycle.

Only registers drive the outputs, so the Gray output cannot glitch. Another clock domain can sample it through its own synchronizer flops, which sit outside this block. A Gray-to-binary decoder is included as a companion circuit, and the block's own checks use it to compare the two registers.

Control is a two-valued step selector with these names:
- HOLD: enable is low, and both registers keep their values.
- STEP: enable is high, and both registers take the next count.

Synchronous reset overrides the selector and clears both registers.

Top module: `gray_step_counter`

## Requirements
- R1: When `rst` is high at a rising edge, both `bin_q` and `gray_q` are zero after that edge.
- R2: Reset takes priority over `en`. An enabled edge with `rst` high still yields zero.
- R3: When `en` is high and `rst` low at an edge, `bin_q` becomes the old value plus one, modulo 2^WIDTH.
- R4: When `en` is low and `rst` low at an edge, both `bin_q` and `gray_q` keep their values.
- R5: In every cycle `gray_q` equals `bin_q ^ (bin_q >> 1)`. The Gray register has no extra cycle of latency.
- R6: The top bit of `gray_q` equals the top bit of `bin_q` in every cycle.
- R7: Every enabled step changes `gray_q` in exactly one bit position. This includes the wrap from all-ones to zero.
- R8: The decoder's result equals `bin_q` when it is applied to `gray_q`. The decoder sets binary bit n to the XOR of Gray bits WIDTH-1 down to n.
- R9: With WIDTH = 4, on each enabled step the new Gray bit 0 equals NOT(G3 XOR G2 XOR G1) of the previous Gray value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable: high selects STEP, low selects HOLD |
| bin_q | output | WIDTH | Registered binary count |
| gray_q | output | WIDTH | Registered Gray code of the same count |

## Verification
The clocked properties assume that `rst` is high at the first rising edge, so that every `$past` reference sees defined state. They also assume that `rst` and `en` are stable around each edge. The stimulus asserts reset from time zero and changes the inputs only one time unit after an edge. It mixes long enabled runs that wrap both an 8-bit and a 4-bit instance with irregular enable gaps. It also applies a reset while enable is high, in the middle of a run.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    // Step selector for the count registers
    typedef enum logic {
        CNT_HOLD = 1'b0,
        CNT_STEP = 1'b1
    } step_e;

endpackage

// File: rtl/gsc_next.sv
module gsc_next #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bin_q,
    input  gsc_pkg::step_e   act,
    output logic [WIDTH-1:0] bin_d
);
    import gsc_pkg::*;

    // Explicit incremented value, the shared source of both registers
    logic [WIDTH-1:0] bin_inc;

    always_comb begin
        bin_inc = bin_q + WIDTH'(1);
    end

    always_comb begin
        unique case (act)
            CNT_STEP: bin_d = bin_inc;
            CNT_HOLD: bin_d = bin_q;
            default:  bin_d = bin_q;
        endcase
    end

endmodule

// File: rtl/gsc_encode.sv
module gsc_encode #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bin_in,
    output logic [WIDTH-1:0] gray_out
);
    localparam int TOP = WIDTH - 1;

    assign gray_out[TOP] = bin_in[TOP];

    genvar n;
    generate
        for (n = 0; n < TOP; n++) begin : g_bit
            assign gray_out[n] = bin_in[n] ^ bin_in[n+1];
        end
    endgenerate

endmodule

// File: rtl/gsc_decode.sv
module gsc_decode #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] bin_out
);
    localparam int TOP = WIDTH - 1;

    assign bin_out[TOP] = gray_in[TOP];

    // Running XOR from the top bit downward
    genvar n;
    generate
        for (n = TOP - 1; n >= 0; n--) begin : g_bit
            assign bin_out[n] = bin_out[n+1] ^ gray_in[n];
        end
    endgenerate

endmodule

// File: rtl/gray_step_counter.sv
module gray_step_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] bin_q,
    output logic [WIDTH-1:0] gray_q
);
    import gsc_pkg::*;

    localparam int TOP = WIDTH - 1;

    step_e            act;
    logic [WIDTH-1:0] bin_d;
    logic [WIDTH-1:0] gray_d;
    logic [WIDTH-1:0] chk_bin;

    always_comb begin
        act = en ? CNT_STEP : CNT_HOLD;
    end

    gsc_next #(.WIDTH(WIDTH)) u_next (
        .bin_q (bin_q),
        .act   (act),
        .bin_d (bin_d)
    );

    // Gray code is formed from the next binary value, not the current one
    gsc_encode #(.WIDTH(WIDTH)) u_enc (
        .bin_in   (bin_d),
        .gray_out (gray_d)
    );

    // Both registers update on the same edge; only these drive the outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= gray_d;
        end
    end

    // Companion decoder, used here to cross-check the two registers
    gsc_decode #(.WIDTH(WIDTH)) u_dec (
        .gray_in (gray_q),
        .bin_out (chk_bin)
    );

    // R1 and R2: reset clears both registers, even with enable high
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (bin_q == '0) && (gray_q == '0));

    // R3: an enabled step increments, wrapping modulo 2^WIDTH
    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        en |=> bin_q == WIDTH'($past(bin_q) + WIDTH'(1)));

    // R4: with enable low, both registers hold
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(bin_q) && $stable(gray_q));

    // R6: the top Gray bit follows the top binary bit
    a_r6_msb_equal: assert property (@(posedge clk) disable iff (rst)
        gray_q[TOP] == bin_q[TOP]);

    // R7: exactly one Gray bit flips per enabled step
    a_r7_one_bit: assert property (@(posedge clk) disable iff (rst)
        en |=> $countones(gray_q ^ $past(gray_q)) == 1);

    // R8: decoding the Gray register gives back the binary register
    a_r8_decode_match: assert property (@(posedge clk) disable iff (rst)
        chk_bin == bin_q);

endmodule

// File: tb/gray_step_counter_test.sv
module gray_step_counter_test;

    localparam int W  = 8;
    localparam int W4 = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [W-1:0]  bin_q, gray_q;
    logic [W4-1:0] bin4, gray4;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    int            ref_cnt = 0;
    logic [W-1:0]  ref_gray = '0;
    logic [W-1:0]  prev_gray = '0;
    logic [W4-1:0] prev_gray4 = '0;

    always #2 clk = ~clk;

    gray_step_counter #(.WIDTH(W)) uut (
        .clk (clk), .rst (rst), .en (en),
        .bin_q (bin_q), .gray_q (gray_q)
    );

    gray_step_counter #(.WIDTH(W4)) uut4 (
        .clk (clk), .rst (rst), .en (en),
        .bin_q (bin4), .gray_q (gray4)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural Gray step: even parity flips bit 0, otherwise the bit above the lowest one
    function automatic logic [W-1:0] gray_advance(input logic [W-1:0] g);
        logic [W-1:0] r = g;
        int lo = W - 1;
        if (^g == 1'b0) begin
            r[0] = ~r[0];
        end else begin
            for (int k = W - 1; k >= 0; k--) if (g[k]) lo = k;
            if (lo + 1 < W) r[lo+1] = ~r[lo+1];
            else r[W-1] = ~r[W-1];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] gray_back(input logic [W-1:0] g);
        logic [W-1:0] b;
        logic acc = 1'b0;
        for (int k = W - 1; k >= 0; k--) begin
            acc  = acc ^ g[k];
            b[k] = acc;
        end
        return b;
    endfunction

    task automatic cycle(input bit r, input bit e);
        logic [W4-1:0] exp4;
        logic [W-1:0]  exp_bin;
        rst = r;
        en  = e;
        prev_gray  = gray_q;
        prev_gray4 = gray4;
        @(posedge clk);
        if (r) begin
            ref_cnt  = 0;
            ref_gray = '0;
        end else if (e) begin
            ref_cnt  = (ref_cnt + 1) % (1 << W);
            ref_gray = gray_advance(ref_gray);
        end
        #1;
        exp_bin = W'(ref_cnt);
        exp4    = W4'(ref_cnt % (1 << W4));
        if (r) begin
            check(bin_q == '0 && gray_q == '0, e ? "R2 reset over enable" : "R1 reset clear",
                  {bin_q, gray_q}, 0);
        end else if (e) begin
            check(bin_q == exp_bin, "R3 increment", bin_q, exp_bin);
            check($countones(gray_q ^ prev_gray) == 1, "R7 single-bit step",
                  gray_q ^ prev_gray, 1);
            check(gray4[0] == ~(prev_gray4[3] ^ prev_gray4[2] ^ prev_gray4[1]),
                  "R9 4-bit bit0 rule", gray4, prev_gray4);
        end else begin
            check(bin_q == exp_bin && gray_q == prev_gray, "R4 hold",
                  {bin_q, gray_q}, {exp_bin, prev_gray});
        end
        check(gray_q == ref_gray, "R5 gray in step", gray_q, ref_gray);
        check(gray_q[W-1] == bin_q[W-1], "R6 msb equal", gray_q[W-1], bin_q[W-1]);
        check(gray_back(gray_q) == bin_q, "R8 decode", gray_back(gray_q), bin_q);
        check(bin4 == exp4 && gray4 == (exp4 ^ (exp4 >> 1)), "R9 4-bit sequence",
              {bin4, gray4}, {exp4, exp4 ^ (exp4 >> 1)});
    endtask

    initial begin
        #1;
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b1);
        // Long enabled run: wraps the 8-bit instance and the 4-bit one many times
        for (int i = 0; i < 300; i++) cycle(1'b0, 1'b1);
        // Irregular enable gaps
        for (int i = 0; i < 200; i++) cycle(1'b0, (i % 7 != 3) && (i % 5 != 0));
        // Reset in the middle of an enabled run
        cycle(1'b1, 1'b1);
        for (int i = 0; i < 40; i++) cycle(1'b0, i[0]);
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0);
        for (int i = 0; i < 260; i++) cycle(1'b0, 1'b1);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule